// File: doc/BRIEF.md
# Divided Delayed Measurement-Start Pulse Generator

This block turns a periodic bus-cycle sync strobe into a one-clock measurement-start strobe. A phase-locked timing source supplies several sync strobes. A selector picks the one that counts. Only every Nth accepted event on that source produces an output. The output strobe can also be pushed later within the bus cycle by a programmable number of clock ticks. The usual setting is the system period minus the sensor's data-valid time. With 10 ns ticks, a 250 µs period and a 112 µs data-valid time, the offset is 13800 ticks, or 138 µs.

The divide factor lets a fast bus drive a slower measurement engine. For example, a 10 kHz bus feeding a measurement engine limited to 2 kHz needs a factor of 5. The block stays silent while its enable bit is clear or while the timing source has not reported that it is ready. Dropping either input cancels any pulse that is still pending and restarts the divide count.

Top module: `meas_start_gen`

## Requirements
- R1: While `pllReady` is low at a clock edge, `startPulse` is low in the following cycle, and a pulse that is still pending is cancelled.
- R2: While `cfgEnable` is low at a clock edge, `startPulse` is low in the following cycle, and a pulse that is still pending is cancelled.
- R3: With divide factor N of 2 or more, only the 1st, (N+1)th, (2N+1)th and later accepted sync events produce a pulse.
- R4: Divide factors 0 and 1 both let every accepted sync event produce a pulse.
- R5: If the selected sync is sampled high at clock edge E and the event fires with offset K, then `startPulse` is high for exactly the one cycle that follows edge E+K. An offset of 0 therefore gives a pulse in the cycle right after E.
- R6: A sync that arrives while a delay is still counting is ignored. It neither starts a new delay nor advances the divide count, and the pending pulse still completes.
- R7: Only `syncIn[cfgSelect]` is a sync event, and the other bits are ignored. Index 1 is the system sync-store strobe.
- R8: Divide factor and offset are sampled at the accepted sync event that fires. Changing them while a delay is counting does not move the pending pulse.
- R9: After `cfgEnable` or `pllReady` has been low, the first accepted sync event fires regardless of the earlier divide phase.
- R10: During reset (`rstN` low), `startPulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick of the offset |
| rstN | input | 1 | Asynchronous active-low reset |
| pllReady | input | 1 | Timing source has finished initialization |
| syncIn | input | NUM_SRC | Sync strobes from the timing source, one per source |
| cfgEnable | input | 1 | Output enable |
| cfgSelect | input | SEL_W | Index of the sync source to use (1 = system sync-store) |
| cfgDivide | input | DIV_W | Divide factor, where 0 behaves as 1 |
| cfgOffset | input | OFF_W | Delay from the sync event, in clock ticks |
| startPulse | output | 1 | One-cycle measurement-start strobe |

## Verification
The assertions take two things for granted:
- Sync strobes are single-cycle pulses on a clean clock, and the reset is released synchronously to the bench's drive edge.
- The zero-offset property reads `cfgOffset` on the same edge that the control launches a delay, so the offset must be stable at that edge.

The bench keeps within these conditions in a simple way. It drives every input on the falling edge and raises each sync for exactly one cycle. It spaces sync events further apart than the programmed offset, except where a test injects a sync on purpose to exercise the ignore rule.

// File: rtl/meas_start_pkg.sv
package meas_start_pkg;
  // Strobes from the control half to the delay datapath.
  typedef struct packed {
    logic clear;   // block inactive: drop pending delay and output
    logic launch;  // firing sync event: start a delay with current offset
  } ctrlStrobe_t;
endpackage

// File: rtl/meas_start_ctrl.sv
module meas_start_ctrl
  import meas_start_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pllReady,
  input  logic               cfgEnable,
  input  logic [SEL_W-1:0]   cfgSelect,
  input  logic [DIV_W-1:0]   cfgDivide,
  input  logic [NUM_SRC-1:0] syncIn,
  input  logic               dpBusy,
  output ctrlStrobe_t        strobe
);
  logic             active;
  logic             selSync;
  logic             accept;
  logic             fireNow;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] reload;

  assign active = cfgEnable & pllReady;

  always_comb begin
    selSync = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfgSelect == SEL_W'(i)) selSync = syncIn[i];
    end
  end

  // Events during a pending delay are discarded completely.
  assign accept  = active & selSync & ~dpBusy;
  assign fireNow = accept & (divCnt == '0);
  // Remaining events to skip after a firing one; factor 0 acts as 1.
  assign reload  = (cfgDivide == '0) ? '0 : cfgDivide - DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!active) begin
      divCnt <= '0;
    end else if (accept) begin
      if (divCnt == '0) divCnt <= reload;
      else              divCnt <= divCnt - DIV_W'(1);
    end
  end

  assign strobe.clear  = ~active;
  assign strobe.launch = fireNow;
endmodule

// File: rtl/meas_start_delay.sv
module meas_start_delay
  import meas_start_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [OFF_W-1:0] cfgOffset,
  output logic             busy,
  output logic             startPulse
);
  logic [OFF_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      tickCnt    <= '0;
      startPulse <= 1'b0;
    end else if (strobe.clear) begin
      busy       <= 1'b0;
      tickCnt    <= '0;
      startPulse <= 1'b0;
    end else if (strobe.launch) begin
      if (cfgOffset == '0) begin
        startPulse <= 1'b1;
      end else begin
        busy       <= 1'b1;
        tickCnt    <= cfgOffset;
        startPulse <= 1'b0;
      end
    end else if (busy) begin
      if (tickCnt == OFF_W'(1)) begin
        busy       <= 1'b0;
        startPulse <= 1'b1;
      end else begin
        startPulse <= 1'b0;
      end
      tickCnt <= tickCnt - OFF_W'(1);
    end else begin
      startPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/meas_start_gen.sv
module meas_start_gen
  import meas_start_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = $clog2(NUM_SRC),
  parameter int DIV_W   = 8,
  parameter int OFF_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pllReady,
  input  logic [NUM_SRC-1:0] syncIn,
  input  logic               cfgEnable,
  input  logic [SEL_W-1:0]   cfgSelect,
  input  logic [DIV_W-1:0]   cfgDivide,
  input  logic [OFF_W-1:0]   cfgOffset,
  output logic               startPulse
);
  ctrlStrobe_t ctrlStrobe;
  logic        dpBusy;

  meas_start_ctrl #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .pllReady(pllReady), .cfgEnable(cfgEnable),
    .cfgSelect(cfgSelect), .cfgDivide(cfgDivide), .syncIn(syncIn),
    .dpBusy(dpBusy), .strobe(ctrlStrobe)
  );

  meas_start_delay #(
    .OFF_W(OFF_W)
  ) i_delay (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .cfgOffset(cfgOffset),
    .busy(dpBusy), .startPulse(startPulse)
  );
endmodule

// File: rtl/meas_start_chk.sv
module meas_start_chk
  import meas_start_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pllReady,
  input logic             cfgEnable,
  input logic [OFF_W-1:0] cfgOffset,
  input ctrlStrobe_t      strobe,
  input logic             dpBusy,
  input logic             startPulse
);
  assert_idle_unready_R1: assert property (@(posedge clk) disable iff (!rstN)
    !pllReady |=> !startPulse);

  assert_idle_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !startPulse);

  assert_zero_offset_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.launch && cfgOffset == '0) |=> startPulse);

  assert_pulse_has_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(strobe.launch || dpBusy));

  assert_pending_blocks_launch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dpBusy && !strobe.clear) |-> !strobe.launch);
endmodule

bind meas_start_gen meas_start_chk #(.OFF_W(OFF_W)) i_meas_start_chk (
  .clk(clk), .rstN(rstN), .pllReady(pllReady), .cfgEnable(cfgEnable),
  .cfgOffset(cfgOffset), .strobe(ctrlStrobe), .dpBusy(dpBusy),
  .startPulse(startPulse)
);

// File: tb/test_meas_start_gen.sv
module test_meas_start_gen;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 8;
  localparam int OFF_W   = 16;

  logic               clk = 1'b0;
  logic               rstN;
  logic               pllReady;
  logic [NUM_SRC-1:0] syncIn;
  logic               cfgEnable;
  logic [SEL_W-1:0]   cfgSelect;
  logic [DIV_W-1:0]   cfgDivide;
  logic [OFF_W-1:0]   cfgOffset;
  logic               startPulse;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  meas_start_gen #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W), .OFF_W(OFF_W))
    i_meas_start_gen (
      .clk(clk), .rstN(rstN), .pllReady(pllReady), .syncIn(syncIn),
      .cfgEnable(cfgEnable), .cfgSelect(cfgSelect), .cfgDivide(cfgDivide),
      .cfgOffset(cfgOffset), .startPulse(startPulse));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called on a falling edge. Raises one sync and watches win cycles.
  // Iteration i samples the cycle after the (i)th rising edge past the sync.
  task automatic syncWatch(input int bitIdx, input int win, input int extraAt,
                           input int dropAt, input int changeAt,
                           input logic [OFF_W-1:0] newOff,
                           output int firstAt, output int count);
    firstAt = -1;
    count   = 0;
    syncIn[bitIdx] = 1'b1;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      syncIn = '0;
      if (startPulse) begin
        if (firstAt < 0) firstAt = i;
        count++;
      end
      if (i == extraAt)  syncIn[bitIdx] = 1'b1;
      if (i == dropAt)   pllReady = 1'b0;
      if (i == changeAt) cfgOffset = newOff;
    end
  endtask

  task automatic simpleSync(input int bitIdx, input int win,
                            output int firstAt, output int count);
    syncWatch(bitIdx, win, -1, -1, -1, '0, firstAt, count);
  endtask

  task automatic setup(input int div, input int off);
    cfgDivide = DIV_W'(div);
    cfgOffset = OFF_W'(off);
    cfgSelect = SEL_W'(1);
    cfgEnable = 1'b0;          // restart divide phase
    @(negedge clk);
    cfgEnable = 1'b1;
    pllReady  = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset;
    check("R10", "startPulse in reset", int'(startPulse), 0);
  endtask

  task automatic testEveryEvent;
    int f, c;
    setup(1, 0);
    simpleSync(1, 4, f, c);
    check("R4", "div1 count", c, 1);
    check("R5", "offset0 position", f, 0);
    setup(0, 0);
    simpleSync(1, 4, f, c);
    check("R4", "div0 count", c, 1);
    simpleSync(1, 4, f, c);
    check("R4", "div0 second count", c, 1);
  endtask

  task automatic testOffset;
    int f, c;
    setup(1, 7);
    simpleSync(1, 12, f, c);
    check("R5", "offset7 position", f, 7);
    check("R5", "offset7 single cycle", c, 1);
    setup(1, 1);
    simpleSync(1, 4, f, c);
    check("R5", "offset1 position", f, 1);
  endtask

  task automatic testDivide;
    int f, c;
    setup(3, 2);
    for (int n = 0; n < 7; n++) begin
      simpleSync(1, 5, f, c);
      check("R3", $sformatf("div3 event %0d count", n), c, (n % 3 == 0) ? 1 : 0);
      if (n % 3 == 0) check("R3", "div3 position", f, 2);
    end
  endtask

  task automatic testIgnorePending;
    int f, c;
    setup(1, 10);
    syncWatch(1, 16, 2, -1, -1, '0, f, c);
    check("R6", "pending pulse position", f, 10);
    check("R6", "extra sync gives no pulse", c, 1);
    setup(2, 5);
    syncWatch(1, 10, 1, -1, -1, '0, f, c);
    check("R6", "div2 first fires", c, 1);
    simpleSync(1, 10, f, c);
    check("R6", "ignored sync not counted", c, 0);
    simpleSync(1, 10, f, c);
    check("R6", "div2 next fires", c, 1);
  endtask

  task automatic testSelect;
    int f, c;
    setup(1, 0);
    simpleSync(0, 4, f, c);
    check("R7", "source 0 ignored", c, 0);
    simpleSync(2, 4, f, c);
    check("R7", "source 2 ignored", c, 0);
    simpleSync(1, 4, f, c);
    check("R7", "source 1 fires", c, 1);
    cfgSelect = SEL_W'(2);
    @(negedge clk);
    simpleSync(2, 4, f, c);
    check("R7", "source 2 selected fires", c, 1);
    simpleSync(1, 4, f, c);
    check("R7", "source 1 now ignored", c, 0);
  endtask

  task automatic testConfigLatch;
    int f, c;
    setup(1, 8);
    syncWatch(1, 12, -1, -1, 2, OFF_W'(3), f, c);
    check("R8", "pending keeps old offset", f, 8);
    simpleSync(1, 6, f, c);
    check("R8", "next event uses new offset", f, 3);
  endtask

  task automatic testReady;
    int f, c;
    setup(1, 10);
    syncWatch(1, 14, -1, 3, -1, '0, f, c);
    check("R1", "pending cancelled by ready drop", c, 0);
    simpleSync(1, 4, f, c);
    check("R1", "sync while unready", c, 0);
    pllReady = 1'b1;
    @(negedge clk);
  endtask

  task automatic testEnable;
    int f, c;
    setup(1, 0);
    cfgEnable = 1'b0;
    @(negedge clk);
    simpleSync(1, 4, f, c);
    check("R2", "sync while disabled", c, 0);
    cfgEnable = 1'b1;
    cfgOffset = OFF_W'(10);
    @(negedge clk);
    syncIn[1] = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      syncIn = '0;
      if (i == 3) cfgEnable = 1'b0;
      if (startPulse) c++;
    end
    check("R2", "pending cancelled by disable", c, 0);
  endtask

  task automatic testRestart;
    int f, c;
    setup(4, 0);
    simpleSync(1, 3, f, c);
    check("R9", "first event fires", c, 1);
    simpleSync(1, 3, f, c);
    check("R9", "second event skipped", c, 0);
    cfgEnable = 1'b0;
    @(negedge clk);
    cfgEnable = 1'b1;
    @(negedge clk);
    simpleSync(1, 3, f, c);
    check("R9", "first after re-enable fires", c, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; pllReady = 1'b0; syncIn = '0; cfgEnable = 1'b0;
    cfgSelect = SEL_W'(1); cfgDivide = '0; cfgOffset = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testEveryEvent();
    testOffset();
    testDivide();
    testIgnorePending();
    testSelect();
    testConfigLatch();
    testReady();
    testEnable();
    testRestart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule